// File: doc/BRIEF.md
# Stepper Phase-to-Step Decoder

This block sits between a disk controller that drives a head stepper as a 2-bit phase code and a head positioner that wants discrete step commands. Every clock it compares the phase code on its input with the last phase it accepted. When the new code is one position ahead in the selected four-position cycle, it issues a one-clock step pulse with an inward direction. When the code is one position behind, it issues the pulse with an outward direction. Any other change is accepted silently and produces no step.

Two phase orderings are supported, chosen by a parameter, because two drive families wire their stepper coils differently. Stepping only happens while the active-low motor enable is asserted. With the motor off, changes on the phase code are ignored and the stored phase is frozen. A signed track counter, saturating at zero and at a parameterised maximum, tracks the net motion of the head.

Top module: `stepper_phase_decoder`

## Requirements
- R1: After reset `step` is 0, `dir` is 0, `track` is 0 and the stored phase is 0, so a first phase of 1 with the motor on gives an inward step.
- R2: With `SEQ_B`=0 the phase order is 0,1,2,3,0: the changes 0→1, 1→2, 2→3 and 3→0 each give one step with `dir`=0 (inward).
- R3: With `SEQ_B`=0 the changes 1→0, 2→1, 3→2 and 0→3 each give one step with `dir`=1 (outward).
- R4: With `SEQ_B`=1 the phase order is 0,1,3,2,0: the changes 0→1, 1→3, 3→2 and 2→0 step with `dir`=0, and their reverses step with `dir`=1.
- R5: A change between two codes two positions apart in the selected order gives no step, but the new code still becomes the stored phase.
- R6: While `motor_n` is 1, phase changes give no step and the stored phase keeps its value; a change seen while the motor was off is decoded once the motor turns on.
- R7: A decoded change raises `step` for exactly one clock, in the cycle after the phase code is sampled; `dir` is valid in that same cycle and holds until the next step.
- R8: `track` rises by 1 on each inward step and falls by 1 on each outward step, saturating at 0 and at `TRACK_MAX`.
- R9: A phase code equal to the stored phase gives no step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| motor_n | input | 1 | Motor enable, active low; stepping is suppressed when high |
| phase | input | 2 | Stepper phase code from the controller |
| step | output | 1 | One-clock step command |
| dir | output | 1 | Step direction, 0 inward, 1 outward |
| track | output | 8 | Signed net track position, 0 to `TRACK_MAX` |

## Verification
Each of `step`, `dir` and `track` is due one clock after the phase code and motor enable are sampled: all three come from the same register stage fed by the stored phase. The bench changes its inputs at a falling edge, lets one rising edge pass, and compares all three outputs at the next falling edge against a bench model that is advanced in that same step. Because the next stimulus is applied at that same falling edge, the cycle after each pulse is also checked, which confirms that the pulse lasts one clock and that the direction holds.

// File: rtl/stepper_phase_decoder.sv
module stepper_phase_decoder #(
  parameter bit SEQ_B     = 1'b0,
  parameter int TRACK_MAX = 76
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              motor_n,
  input  logic [1:0]        phase,
  output logic              step,
  output logic              dir,
  output logic signed [7:0] track
);

  localparam logic signed [7:0] TMAX = 8'(TRACK_MAX);

  logic [1:0] prev_q;

  // position of a phase code within the selected four-step cycle
  function automatic logic [1:0] pos_of(input logic [1:0] p);
    return SEQ_B ? {p[1], p[1] ^ p[0]} : p;
  endfunction

  wire [1:0] delta   = pos_of(phase) - pos_of(prev_q);
  wire       changed = !motor_n && (phase != prev_q);
  wire       go_in   = changed && (delta == 2'd1);
  wire       go_out  = changed && (delta == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 2'd0;
      step   <= 1'b0;
      dir    <= 1'b0;
      track  <= 8'sd0;
    end else begin
      step <= go_in | go_out;
      if (changed)
        prev_q <= phase;
      if (go_in | go_out)
        dir <= go_out;
      if (go_in && track < TMAX)
        track <= track + 8'sd1;
      else if (go_out && track > 8'sd0)
        track <= track - 8'sd1;
    end
  end

endmodule

// File: rtl/stepper_phase_decoder_chk.sv
module stepper_phase_decoder_chk #(
  parameter int TRACK_MAX = 76
) (
  input logic              clk,
  input logic              rst_n,
  input logic              motor_n,
  input logic [1:0]        phase,
  input logic [1:0]        prev_q,
  input logic              step,
  input logic              dir,
  input logic signed [7:0] track
);

  localparam logic signed [7:0] TMAX = 8'(TRACK_MAX);

  a_r6_motor_off_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(motor_n) |-> !step);

  a_r6_prev_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    motor_n |=> $stable(prev_q));

  a_r9_step_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ($past(phase) != $past(prev_q)));

  a_r7_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> $stable(dir));

  a_r8_track_still: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> $stable(track));

  a_r8_track_range: assert property (@(posedge clk) disable iff (!rst_n)
    (track >= 8'sd0) && (track <= TMAX));

  a_r8_inward_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dir && $past(track) != TMAX) |-> (track == $past(track) + 8'sd1));

  a_r8_outward_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dir && $past(track) != 8'sd0) |-> (track == $past(track) - 8'sd1));

endmodule

bind stepper_phase_decoder stepper_phase_decoder_chk #(.TRACK_MAX(TRACK_MAX)) chk (
  .clk(clk), .rst_n(rst_n), .motor_n(motor_n), .phase(phase),
  .prev_q(prev_q), .step(step), .dir(dir), .track(track)
);

// File: tb/stepper_phase_decoder_test.sv
module stepper_phase_decoder_test;
  localparam int TMAX = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic motor_n = 1'b1;
  logic [1:0] phase = 2'd0;
  logic step_a, dir_a, step_b, dir_b;
  logic signed [7:0] track_a, track_b;

  int checks = 0;
  int errors = 0;

  logic [1:0] m_prev [2];
  logic       m_step [2];
  logic       m_dir  [2];
  int         m_trk  [2];

  always #5 clk = ~clk;

  stepper_phase_decoder #(.SEQ_B(1'b0), .TRACK_MAX(TMAX)) uut (
    .clk(clk), .rst_n(rst_n), .motor_n(motor_n), .phase(phase),
    .step(step_a), .dir(dir_a), .track(track_a));

  stepper_phase_decoder #(.SEQ_B(1'b1), .TRACK_MAX(TMAX)) uut_b (
    .clk(clk), .rst_n(rst_n), .motor_n(motor_n), .phase(phase),
    .step(step_b), .dir(dir_b), .track(track_b));

  function automatic int pos_f(input int s, input logic [1:0] p);
    if (s == 0) return int'(p);
    case (p)
      2'd0: return 0;
      2'd1: return 1;
      2'd3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(input int got, input int exp, input string tag, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] ph, input logic mot, input string tag);
    phase = ph;
    motor_n = mot;
    for (int s = 0; s < 2; s++) begin
      m_step[s] = 1'b0;
      if (!mot && ph != m_prev[s]) begin
        int d;
        d = (pos_f(s, ph) - pos_f(s, m_prev[s]) + 4) % 4;
        if (d == 1) begin
          m_step[s] = 1'b1; m_dir[s] = 1'b0;
          if (m_trk[s] < TMAX) m_trk[s]++;
        end else if (d == 3) begin
          m_step[s] = 1'b1; m_dir[s] = 1'b1;
          if (m_trk[s] > 0) m_trk[s]--;
        end
        m_prev[s] = ph;
      end
    end
    @(negedge clk);
    check(int'(step_a), int'(m_step[0]), tag, "step seqA");
    check(int'(dir_a), int'(m_dir[0]), tag, "dir seqA");
    check(int'(track_a), m_trk[0], tag, "track seqA");
    check(int'(step_b), int'(m_step[1]), tag, "step seqB");
    check(int'(dir_b), int'(m_dir[1]), tag, "dir seqB");
    check(int'(track_b), m_trk[1], tag, "track seqB");
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 2; s++) begin
      m_prev[s] = 2'd0; m_step[s] = 1'b0; m_dir[s] = 1'b0; m_trk[s] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(int'(step_a), 0, "R1", "step seqA");
    check(int'(dir_a), 0, "R1", "dir seqA");
    check(int'(track_a), 0, "R1", "track seqA");
    check(int'(step_b), 0, "R1", "step seqB");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: stored phase is 0, so 1 is an inward step
    apply(2'd1, 1'b0, "R1");
    // R9 and R7: same phase, pulse drops, dir held
    apply(2'd1, 1'b0, "R9");
    apply(2'd1, 1'b0, "R7");
    // R2: sequence A inward ring
    apply(2'd2, 1'b0, "R2");
    apply(2'd3, 1'b0, "R2");
    apply(2'd0, 1'b0, "R2");
    apply(2'd1, 1'b0, "R2");
    // R3: sequence A outward ring
    apply(2'd0, 1'b0, "R3");
    apply(2'd3, 1'b0, "R3");
    apply(2'd2, 1'b0, "R3");
    apply(2'd1, 1'b0, "R3");
    apply(2'd0, 1'b0, "R3");
    // R4: sequence B inward then outward
    apply(2'd1, 1'b0, "R4");
    apply(2'd3, 1'b0, "R4");
    apply(2'd2, 1'b0, "R4");
    apply(2'd0, 1'b0, "R4");
    apply(2'd2, 1'b0, "R4");
    apply(2'd3, 1'b0, "R4");
    apply(2'd1, 1'b0, "R4");
    apply(2'd0, 1'b0, "R4");
    // R5: jumps, then a neighbour step proves the store moved
    apply(2'd2, 1'b0, "R5");
    apply(2'd3, 1'b0, "R5");
    apply(2'd1, 1'b0, "R5");
    apply(2'd0, 1'b0, "R5");
    // R6: motor off freezes the stored phase
    apply(2'd1, 1'b1, "R6");
    apply(2'd2, 1'b1, "R6");
    apply(2'd1, 1'b1, "R6");
    apply(2'd1, 1'b0, "R6");
    // R8: drive to the upper limit and beyond
    for (int k = 0; k < 12; k++) apply(2'((k + 2) % 4), 1'b0, "R8");
    // R8: drive down to zero and beyond
    for (int k = 0; k < 14; k++) apply(2'((13 - k) % 4), 1'b0, "R8");
    // random mix
    for (int k = 0; k < 3000; k++)
      apply(2'($urandom_range(0, 3)), ($urandom_range(0, 4) == 0), "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule